// File: doc/BRIEF.md
# Grouped Interrupt Cause and Mask Controller

This block collects interrupt events for several independent groups, each holding a 32-bit cause register, a 32-bit mask register, a 32-bit abort mask and a small control register. Hardware events set cause bits. Software reaches all registers through one simple read/write port that is steered by a group index and a register select. Software can set and clear cause bits directly, and it can read the cause register with an optional clear on the read. The mask has two write ports: a set port and a separate clear port. Because each bit written as 1 changes only that bit, software can unmask a source without a read-modify-write. This stays safe while hardware is masking sources on its own.

Each group drives an interrupt line, which is the OR of its pending unmasked cause bits. It also drives an abort line, which applies the same rule through the abort mask. In auto-mask mode the hardware sets a source's mask bit once that source has been presented on the interrupt line. The line therefore pulses for a single cycle per event, and software re-arms the source with one mask-clear write.

Top module: `intr_grp_top`

## Requirements
- R1: After reset every group has cause = 0, mask = all ones, abort mask = all ones and control = 0, so both outputs of every group are low.
- R2: A group's irq_o bit is high exactly when at least one of its cause bits is 1 and the matching mask bit is 0. It follows the register state with no added delay.
- R3: An event input bit held high for one cycle sets the matching cause bit on that clock edge, and the bit stays set until software clears it.
- R4: A write to select 1 sets the cause bits written as 1. A write to select 2 clears the cause bits written as 1 and leaves the others unchanged. An event and a clear on the same bit in the same cycle leave the bit set.
- R5: A write to select 3 sets the mask bits written as 1. A write to select 4 clears the mask bits written as 1. Bits written as 0 are unchanged in both cases, and select 3 reads the mask.
- R6: A group's abort_o bit is high exactly when some cause bit is 1 and the matching abort mask bit is 0. Select 5 writes and reads the whole abort mask.
- R7: Select 6 holds the control flags: bit 0 enables clear-on-read and bit 1 enables auto-mask. All other bits are ignored on write and read as 0.
- R8: A read of select 0 returns the cause register. With clear-on-read enabled, the returned bits are cleared, but an event arriving in the same cycle is kept.
- R9: With auto-mask enabled, a cause bit that is pending and unmasked gets its mask bit set on the next clock edge, so irq_o pulses for one cycle.
- R10: grp_i picks which group a read or write reaches, and the other groups are left unchanged.
- R11: rdata_o takes the selected value on the clock edge after rd_en_i and holds it until the next read. Select 7 reads 0, and writes to selects 0 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_GROUPS*WIDTH | Event inputs; group g occupies bits g*WIDTH and up |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| grp_i | input | GRP_W | Group index |
| sel_i | input | 3 | Register select (0 cause, 1 cause set, 2 cause clear, 3 mask/mask set, 4 mask clear, 5 abort mask, 6 control) |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Registered read data |
| irq_o | output | NUM_GROUPS | Interrupt line per group |
| abort_o | output | NUM_GROUPS | Abort line per group |

## Verification
The cause/mask function is driven with several patterns, and each one separates a different faulty behaviour:
- Partial clear patterns show whether a clear leaves the untouched bits alone.
- Mask-set and mask-clear patterns on the same bits show whether the two ports are swapped or overwrite the whole mask.
- Writes to one group followed by reads of another show whether group decode leaks between groups.
- A read and an event on the same cycle under clear-on-read, and a cause clear racing an event, show whether the set-priority merge is correct.
- An auto-mask event checked on two consecutive cycles tells a one-cycle interrupt pulse apart from a stuck or missing one.

// File: rtl/intr_grp_pkg.sv
package intr_grp_pkg;

    // Register select codes (sel_i)
    typedef enum logic [2:0] {
        SEL_CAUSE      = 3'd0,
        SEL_CAUSE_SET  = 3'd1,
        SEL_CAUSE_CLR  = 3'd2,
        SEL_MASK       = 3'd3,
        SEL_MASK_CLR   = 3'd4,
        SEL_ABORT_MASK = 3'd5,
        SEL_CTRL       = 3'd6,
        SEL_RSVD       = 3'd7
    } reg_sel_e;

    // Control flags: bit 1 auto-mask, bit 0 clear-on-read
    typedef struct packed {
        logic auto_mask;
        logic clr_on_rd;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/intr_grp_decode.sv
module intr_grp_decode #(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 2
) (
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [GRP_W-1:0]      grp_i,
    output logic [NUM_GROUPS-1:0] wr_vec_o,
    output logic [NUM_GROUPS-1:0] rd_vec_o
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
        localparam logic [GRP_W-1:0] IDX = GRP_W'(g);
        assign wr_vec_o[g] = wr_en_i && (grp_i == IDX);
        assign rd_vec_o[g] = rd_en_i && (grp_i == IDX);
    end

endmodule

// File: rtl/intr_grp_unit.sv
module intr_grp_unit
    import intr_grp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  evt_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [2:0]        sel_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  cause_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic [WIDTH-1:0]  abort_mask_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o,
    output logic              abort_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cause;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] abort_mask;
        ctrl_t            ctrl;
    } state_t;

    state_t           st_d, st_q;
    reg_sel_e         sel;
    logic [WIDTH-1:0] sw_set, sw_clr, rd_clr, m_set, m_clr, pending, auto_set;

    assign sel      = reg_sel_e'(sel_i);
    assign sw_set   = (wr_i && sel == SEL_CAUSE_SET) ? wdata_i : '0;
    assign sw_clr   = (wr_i && sel == SEL_CAUSE_CLR) ? wdata_i : '0;
    assign m_set    = (wr_i && sel == SEL_MASK)      ? wdata_i : '0;
    assign m_clr    = (wr_i && sel == SEL_MASK_CLR)  ? wdata_i : '0;
    assign rd_clr   = (rd_i && sel == SEL_CAUSE && st_q.ctrl.clr_on_rd) ? st_q.cause : '0;
    assign pending  = st_q.cause & ~st_q.mask;
    assign auto_set = st_q.ctrl.auto_mask ? pending : '0;

    always_comb begin
        st_d = st_q;
        // Sets win over clears so no event is lost
        st_d.cause = (st_q.cause & ~(sw_clr | rd_clr)) | evt_i | sw_set;
        st_d.mask  = (st_q.mask & ~m_clr) | m_set | auto_set;
        if (wr_i && sel == SEL_ABORT_MASK) begin
            st_d.abort_mask = wdata_i;
        end
        if (wr_i && sel == SEL_CTRL) begin
            st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cause      <= '0;
            st_q.mask       <= '1;
            st_q.abort_mask <= '1;
            st_q.ctrl       <= ctrl_t'('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o      = st_q.cause;
    assign mask_o       = st_q.mask;
    assign abort_mask_o = st_q.abort_mask;
    assign ctrl_o       = st_q.ctrl;
    assign irq_o        = |pending;
    assign abort_o      = |(st_q.cause & ~st_q.abort_mask);

    // R2: a fully masked group never interrupts
    a_r2_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |-> !irq_o);

    // R3: an event bit is latched on the next edge
    a_r3_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.cause & $past(evt_i)) == $past(evt_i)));

    // R4: software-set cause bits are present after the write
    a_r4_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == 3'd1) |=> ((st_q.cause & $past(wdata_i)) == $past(wdata_i)));

    // R5: mask-clear without auto-mask leaves the written bits unmasked
    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == 3'd4 && !st_q.ctrl.auto_mask) |=> ((st_q.mask & $past(wdata_i)) == '0));

    // R8: clear-on-read removes the returned bits unless re-set by an event
    a_r8_clr_on_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && sel_i == 3'd0 && st_q.ctrl.clr_on_rd)
            |=> ((st_q.cause & $past(st_q.cause & ~evt_i)) == '0));

    // R9: auto-mask masks every source that was presented
    a_r9_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.auto_mask && (|pending)) |=> ((st_q.mask & $past(pending)) == $past(pending)));

endmodule

// File: rtl/intr_grp_rdmux.sv
module intr_grp_rdmux
    import intr_grp_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int WIDTH      = 32,
    parameter int GRP_W      = 2
) (
    input  logic [GRP_W-1:0]             grp_i,
    input  logic [2:0]                   sel_i,
    input  logic [NUM_GROUPS*WIDTH-1:0]  cause_i,
    input  logic [NUM_GROUPS*WIDTH-1:0]  mask_i,
    input  logic [NUM_GROUPS*WIDTH-1:0]  abort_mask_i,
    input  logic [NUM_GROUPS*CTRL_W-1:0] ctrl_i,
    output logic [WIDTH-1:0]             data_o
);

    localparam int PAD_W = WIDTH - CTRL_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(sel_i);

    always_comb begin
        data_o = '0;
        case (sel)
            SEL_CAUSE:      data_o = cause_i[grp_i*WIDTH +: WIDTH];
            SEL_MASK:       data_o = mask_i[grp_i*WIDTH +: WIDTH];
            SEL_ABORT_MASK: data_o = abort_mask_i[grp_i*WIDTH +: WIDTH];
            SEL_CTRL:       data_o = {{PAD_W{1'b0}}, ctrl_i[grp_i*CTRL_W +: CTRL_W]};
            default:        data_o = '0;
        endcase
    end

endmodule

// File: rtl/intr_grp_top.sv
module intr_grp_top
    import intr_grp_pkg::*;
#(
    parameter int NUM_GROUPS = 4,   // power of two, at least 2
    parameter int WIDTH      = 32,
    parameter int GRP_W      = $clog2(NUM_GROUPS) // derived
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*WIDTH-1:0] evt_i,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [GRP_W-1:0]            grp_i,
    input  logic [2:0]                  sel_i,
    input  logic [WIDTH-1:0]            wdata_i,
    output logic [WIDTH-1:0]            rdata_o,
    output logic [NUM_GROUPS-1:0]       irq_o,
    output logic [NUM_GROUPS-1:0]       abort_o
);

    localparam int ALL_W = NUM_GROUPS * WIDTH;

    logic [NUM_GROUPS-1:0]        wr_vec, rd_vec;
    logic [ALL_W-1:0]             cause_all, mask_all, abort_all;
    logic [NUM_GROUPS*CTRL_W-1:0] ctrl_all;
    logic [WIDTH-1:0]             rd_mux, rdata_d, rdata_q;

    intr_grp_decode #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) dec_i (
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .grp_i    (grp_i),
        .wr_vec_o (wr_vec),
        .rd_vec_o (rd_vec)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_unit
        intr_grp_unit #(.WIDTH(WIDTH)) unit_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt_i[g*WIDTH +: WIDTH]),
            .wr_i         (wr_vec[g]),
            .rd_i         (rd_vec[g]),
            .sel_i        (sel_i),
            .wdata_i      (wdata_i),
            .cause_o      (cause_all[g*WIDTH +: WIDTH]),
            .mask_o       (mask_all[g*WIDTH +: WIDTH]),
            .abort_mask_o (abort_all[g*WIDTH +: WIDTH]),
            .ctrl_o       (ctrl_all[g*CTRL_W +: CTRL_W]),
            .irq_o        (irq_o[g]),
            .abort_o      (abort_o[g])
        );
    end

    intr_grp_rdmux #(.NUM_GROUPS(NUM_GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W)) mux_i (
        .grp_i        (grp_i),
        .sel_i        (sel_i),
        .cause_i      (cause_all),
        .mask_i       (mask_all),
        .abort_mask_i (abort_all),
        .ctrl_i       (ctrl_all),
        .data_o       (rd_mux)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

    // R11: read data holds between reads
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    // R11: reserved select reads zero
    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel_i == 3'd7) |=> (rdata_o == '0));

endmodule

// File: tb/intr_grp_top_tb_top.sv
module intr_grp_top_tb_top;

    localparam int NG = 4;
    localparam int W  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG*W-1:0] evt = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]      grp = '0;
    logic [2:0]      sel = '0;
    logic [W-1:0]    wdata = '0;
    logic [W-1:0]    rdata;
    logic [NG-1:0]   irq, abrt;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    intr_grp_top #(.NUM_GROUPS(NG), .WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .grp_i(grp), .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .abort_o(abrt)
    );

    typedef struct packed {
        logic        rd;
        logic [1:0]  g;
        logic [2:0]  s;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 3'd3, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 mask reset
        '{1'b1, 2'd0, 3'd5, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 abort mask reset
        '{1'b1, 2'd0, 3'd6, 32'h0,         32'h0,         4'd1},  // R1 control reset
        '{1'b1, 2'd0, 3'd0, 32'h0,         32'h0,         4'd1},  // R1 cause reset
        '{1'b0, 2'd0, 3'd1, 32'h0000_00F0, 32'h0,         4'd4},  // R4 cause set
        '{1'b1, 2'd0, 3'd0, 32'h0,         32'h0000_00F0, 4'd4},
        '{1'b0, 2'd0, 3'd2, 32'h0000_0030, 32'h0,         4'd4},  // R4 partial clear
        '{1'b1, 2'd0, 3'd0, 32'h0,         32'h0000_00C0, 4'd4},
        '{1'b0, 2'd0, 3'd4, 32'h0000_00FF, 32'h0,         4'd5},  // R5 mask clear
        '{1'b1, 2'd0, 3'd3, 32'h0,         32'hFFFF_FF00, 4'd5},
        '{1'b0, 2'd0, 3'd3, 32'h0000_000F, 32'h0,         4'd5},  // R5 mask set
        '{1'b1, 2'd0, 3'd3, 32'h0,         32'hFFFF_FF0F, 4'd5},
        '{1'b0, 2'd1, 3'd1, 32'h0A00_0000, 32'h0,         4'd10}, // R10 other group
        '{1'b1, 2'd1, 3'd0, 32'h0,         32'h0A00_0000, 4'd10},
        '{1'b1, 2'd0, 3'd0, 32'h0,         32'h0000_00C0, 4'd10},
        '{1'b0, 2'd2, 3'd5, 32'h1234_5678, 32'h0,         4'd6},  // R6 abort mask
        '{1'b1, 2'd2, 3'd5, 32'h0,         32'h1234_5678, 4'd6},
        '{1'b0, 2'd3, 3'd6, 32'hFFFF_FFFF, 32'h0,         4'd7},  // R7 control
        '{1'b1, 2'd3, 3'd6, 32'h0,         32'h0000_0003, 4'd7},
        '{1'b0, 2'd3, 3'd0, 32'hFFFF_FFFF, 32'h0,         4'd11}, // R11 write to cause ignored
        '{1'b1, 2'd3, 3'd7, 32'h0,         32'h0,         4'd11}  // R11 reserved reads 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic do_write(input logic [1:0] g, input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; grp = g; sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] g, input logic [2:0] s, output logic [31:0] d);
        rd_en = 1'b1; grp = g; sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_evt(input int bitpos);
        evt[bitpos] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {28'h0, irq}, 32'h0);
        check("R1 abort after reset", {28'h0, abrt}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                do_read(VEC[i].g, VEC[i].s, rv);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].exp);
            end else begin
                do_write(VEC[i].g, VEC[i].s, VEC[i].data);
            end
        end

        // R2: g0 cause C0, mask FFFFFF0F -> only group 0 interrupts
        check("R2 irq vector", {28'h0, irq}, 32'h1);
        check("R6 abort idle", {28'h0, abrt}, 32'h0);
        // R6: unmask abort bit 7 of group 0
        do_write(2'd0, 3'd5, 32'hFFFF_FF7F);
        check("R6 abort raised", {28'h0, abrt}, 32'h1);
        // R2/R5: masking the pending bits drops the line
        do_write(2'd0, 3'd3, 32'h0000_00C0);
        check("R2 irq masked", {28'h0, irq}, 32'h0);

        // R3: event latches and stays
        pulse_evt(1*W + 0);
        do_read(2'd1, 3'd0, rv);
        check("R3 event latched", rv, 32'h0A00_0001);
        do_read(2'd1, 3'd0, rv);
        check("R3 event held", rv, 32'h0A00_0001);
        do_write(2'd1, 3'd4, 32'h0000_0001);
        check("R2 irq group1", {28'h0, irq}, 32'h2);

        // R4: clear and event on the same bit, event wins
        evt[6] = 1'b1;
        do_write(2'd0, 3'd2, 32'h0000_0040);
        evt = '0;
        do_read(2'd0, 3'd0, rv);
        check("R4 set beats clear", rv, 32'h0000_00C0);

        // R8: clear-on-read on group 2
        do_write(2'd2, 3'd6, 32'h0000_0001);
        do_write(2'd2, 3'd1, 32'h0000_FF00);
        do_read(2'd2, 3'd0, rv);
        check("R8 read returns cause", rv, 32'h0000_FF00);
        do_read(2'd2, 3'd0, rv);
        check("R8 cleared by read", rv, 32'h0);
        do_write(2'd2, 3'd1, 32'h0000_0005);
        evt[2*W + 8] = 1'b1;
        do_read(2'd2, 3'd0, rv);
        evt = '0;
        check("R8 read with event", rv, 32'h0000_0005);
        do_read(2'd2, 3'd0, rv);
        check("R8 event kept", rv, 32'h0000_0100);

        // R9: auto-mask on group 3 (control already 3)
        do_write(2'd3, 3'd4, 32'h0000_0010);
        check("R9 idle before event", {31'h0, irq[3]}, 32'h0);
        pulse_evt(3*W + 4);
        check("R9 irq pulse high", {31'h0, irq[3]}, 32'h1);
        @(negedge clk);
        check("R9 irq pulse ends", {31'h0, irq[3]}, 32'h0);
        do_read(2'd3, 3'd3, rv);
        check("R9 mask re-set", rv, 32'hFFFF_FFFF);
        do_write(2'd3, 3'd4, 32'h0000_0010);
        check("R9 re-arm high", {31'h0, irq[3]}, 32'h1);
        @(negedge clk);
        check("R9 re-arm ends", {31'h0, irq[3]}, 32'h0);

        // R11: data holds without a read
        do_read(2'd0, 3'd5, rv);
        repeat (3) @(negedge clk);
        check("R11 rdata hold", rdata, 32'hFFFF_FF7F);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule